// File: doc/BRIEF.md
# Panel Initialisation Command Sequencer

This block brings a 240x400 display panel from reset to a state where a pixel source can stream into its frame memory. A single start pulse makes it walk an internal configuration table onto a write-only command/parameter bus. It inserts the waits the panel needs after leaving sleep and after turning the display on. It clears the entire frame memory to black, switches the display on, and leaves the panel in memory-write mode. It then raises `ready` so that the pixel path can take over the bus.

The bus carries one write per clock on `wr_stb`. `rs` tells the panel whether the write is a command or a parameter, and `wdata` carries the 18-bit value. The configuration table is built from a list of commands, each pointing at a parameter list, with typed entries for commands, parameters, delays and the end of the table. The window commands follow the panel dimensions. The frame clear does not come from the table: a counter produces it.

Top module: `panel_init_seq`

## Requirements
- R1: After reset, `wr_stb`, `busy` and `ready` are low, and no write happens until `start` is seen.
- R2: When `start` is sampled high while `busy` and `ready` are both low, `busy` is high on the next cycle. The first write, command 0xB0, follows one cycle later.
- R3: A command write has `rs`=0 and a parameter write has `rs`=1. The 8-bit value sits in `wdata[7:0]` with the upper bits zero. The configuration commands are issued in this order, each followed by the given number of parameter writes: B0/1, B1/1, B3/5, B4/1, C0/9, C1/5, C2/5, C3/5, C4/4, C8/20, C9/20, CA/20, D0/6, D1/3, D2/2, D3/2, D4/2, D8/2.
- R4: The parameter lists of 0xC8, 0xC9 and 0xCA are identical. The lists of 0xC1, 0xC2 and 0xC3 are identical.
- R5: After the configuration commands, the tearing-effect output is enabled with command 0x35 and parameter 0x00. Its scan line is then set with command 0x44 and parameters 0x00, 0x00.
- R6: The column window is set with command 0x2A and parameters 0x00, 0x00, then (COLS-1) high byte and low byte. The row window is set with 0x2B and parameters 0x00, 0x00, then (ROWS-1) high byte and low byte. With the default 240x400 panel the end values are 0x00EF and 0x018F.
- R7: Sleep exit, command 0x11, follows the row window. The next write comes no sooner than SLEEP_US*CYC_PER_US cycles after it and no more than 4 cycles later than that.
- R8: After the sleep wait, command 0x2C is followed by exactly COLS*ROWS parameter writes of value 0.
- R9: Command 0x29 follows the clear. Command 0x2C follows it after a gap of at least DISP_US*CYC_PER_US cycles and at most 4 cycles more.
- R10: On the cycle after that final 0x2C write, `ready` is high and `busy` is low. `ready` then holds until the next `start` and no further writes occur. `busy` and `ready` are never high together, and every write happens while `busy` is high.
- R11: Outside the two waits of R7 and R9, writes are issued on consecutive clock cycles.
- R12: A `start` pulse while `busy` is high has no effect on the write stream.
- R13: A `start` pulse while `ready` is high lowers `ready`, raises `busy` on the next cycle, and repeats the whole sequence from 0xB0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin (or repeat) the initialisation sequence |
| wr_stb | output | 1 | One-cycle strobe per bus write |
| rs | output | 1 | Register select: 0 command, 1 parameter |
| wdata | output | 18 | Write data for the panel bus |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Panel initialised and left in memory-write mode |

## Verification
The hardest situations to reach from the ports are `start` arriving in the middle of a running sequence and `start` arriving during one of the long waits. Either one, if mishandled, would silently restart or shorten the sequence. The bench pulses `start` once while the table is being walked and once inside the sleep wait. It then relies on its reference stream, which also checks the gap before every write, to show that nothing moved. The sequence is run a second time from the ready state to exercise the restart path. The bench uses a reduced panel and short waits, so that the full clear and both waits complete within the run.

// File: rtl/pinit_pkg.sv
package pinit_pkg;

    typedef enum logic [1:0] {
        ENT_CMD   = 2'd0,
        ENT_PARAM = 2'd1,
        ENT_DELAY = 2'd2,
        ENT_END   = 2'd3
    } ent_kind_e;

    typedef struct packed {
        ent_kind_e   kind;
        logic [17:0] value;
    } ent_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WALK,
        ST_WAIT,
        ST_FILL_CMD,
        ST_FILL,
        ST_DISP,
        ST_DISP_WAIT,
        ST_REARM,
        ST_READY
    } seq_state_e;

    localparam int NUM_GRP    = 25;
    localparam int GRP_W      = $clog2(NUM_GRP);
    localparam int MAX_PARAMS = 20;
    localparam int POS_W      = $clog2(MAX_PARAMS + 1);
    localparam int LIST_W     = 8 * MAX_PARAMS;

    localparam logic [7:0] CMD_SLEEP_OUT = 8'h11;
    localparam logic [7:0] CMD_DISP_ON   = 8'h29;
    localparam logic [7:0] CMD_COL_WIN   = 8'h2A;
    localparam logic [7:0] CMD_ROW_WIN   = 8'h2B;
    localparam logic [7:0] CMD_MEM_WR    = 8'h2C;
    localparam logic [7:0] CMD_TE_ON     = 8'h35;
    localparam logic [7:0] CMD_TE_LINE   = 8'h44;

endpackage

// File: rtl/pinit_rom.sv
module pinit_rom
    import pinit_pkg::*;
#(
    parameter int COLS     = 240,
    parameter int ROWS     = 400,
    parameter int SLEEP_US = 120000
) (
    input  logic [GRP_W-1:0] grp,
    input  logic [POS_W-1:0] pos,
    output ent_t             ent,
    output logic             last
);

    localparam logic [15:0] COL_END  = 16'(COLS - 1);
    localparam logic [15:0] ROW_END  = 16'(ROWS - 1);
    localparam logic [7:0]  ROW_CODE = 8'(ROWS / 4 - 1);

    // parameter lists, first byte in the most significant position
    localparam logic [LIST_W-1:0] L_ZERO  = '0;
    localparam logic [LIST_W-1:0] L_FMIF  = {40'h02_00_00_00_02, 120'd0};
    localparam logic [LIST_W-1:0] L_PANEL = {8'h0B, ROW_CODE, 56'h04_00_00_04_11_00_00, 88'd0};
    localparam logic [LIST_W-1:0] L_TIM   = {40'h00_00_13_08_08, 120'd0};
    localparam logic [LIST_W-1:0] L_TSRC  = {32'h11_01_00_01, 128'd0};
    localparam logic [LIST_W-1:0] L_GAMMA = {80'h01_02_08_23_03_0C_00_06_00_00,
                                             80'h01_00_0C_23_03_08_02_06_00_00};
    localparam logic [LIST_W-1:0] L_PWR   = {48'h07_C5_DC_02_33_0A, 112'd0};
    localparam logic [LIST_W-1:0] L_VCOM  = {24'h00_0F_02, 136'd0};
    localparam logic [LIST_W-1:0] L_PMODE = {16'h63_24, 144'd0};
    localparam logic [LIST_W-1:0] L_AUX   = {16'h77_77, 144'd0};
    localparam logic [LIST_W-1:0] L_COL   = {16'h0000, COL_END, 128'd0};
    localparam logic [LIST_W-1:0] L_ROW   = {16'h0000, ROW_END, 128'd0};

    ent_kind_e         gk;
    logic [7:0]        gcmd;
    logic [LIST_W-1:0] glist;
    logic [POS_W-1:0]  glen;
    logic [7:0]        pbyte;
    int                sh;

    always_comb begin
        gk    = ENT_CMD;
        gcmd  = 8'h00;
        glist = L_ZERO;
        glen  = '0;
        case (grp)
            5'd0:  begin gcmd = 8'hB0; glen = 5'd1; end
            5'd1:  begin gcmd = 8'hB1; glen = 5'd1; end
            5'd2:  begin gcmd = 8'hB3; glist = L_FMIF;  glen = 5'd5;  end
            5'd3:  begin gcmd = 8'hB4; glen = 5'd1; end
            5'd4:  begin gcmd = 8'hC0; glist = L_PANEL; glen = 5'd9;  end
            5'd5:  begin gcmd = 8'hC1; glist = L_TIM;   glen = 5'd5;  end
            5'd6:  begin gcmd = 8'hC2; glist = L_TIM;   glen = 5'd5;  end
            5'd7:  begin gcmd = 8'hC3; glist = L_TIM;   glen = 5'd5;  end
            5'd8:  begin gcmd = 8'hC4; glist = L_TSRC;  glen = 5'd4;  end
            5'd9:  begin gcmd = 8'hC8; glist = L_GAMMA; glen = 5'd20; end
            5'd10: begin gcmd = 8'hC9; glist = L_GAMMA; glen = 5'd20; end
            5'd11: begin gcmd = 8'hCA; glist = L_GAMMA; glen = 5'd20; end
            5'd12: begin gcmd = 8'hD0; glist = L_PWR;   glen = 5'd6;  end
            5'd13: begin gcmd = 8'hD1; glist = L_VCOM;  glen = 5'd3;  end
            5'd14: begin gcmd = 8'hD2; glist = L_PMODE; glen = 5'd2;  end
            5'd15: begin gcmd = 8'hD3; glist = L_PMODE; glen = 5'd2;  end
            5'd16: begin gcmd = 8'hD4; glist = L_PMODE; glen = 5'd2;  end
            5'd17: begin gcmd = 8'hD8; glist = L_AUX;   glen = 5'd2;  end
            5'd18: begin gcmd = CMD_TE_ON;   glen = 5'd1; end
            5'd19: begin gcmd = CMD_TE_LINE; glen = 5'd2; end
            5'd20: begin gcmd = CMD_COL_WIN; glist = L_COL; glen = 5'd4; end
            5'd21: begin gcmd = CMD_ROW_WIN; glist = L_ROW; glen = 5'd4; end
            5'd22: begin gcmd = CMD_SLEEP_OUT; end
            5'd23: gk = ENT_DELAY;
            default: gk = ENT_END;
        endcase

        sh    = 8 * (MAX_PARAMS - int'(pos));
        pbyte = 8'(glist >> sh);

        case (gk)
            ENT_CMD: begin
                ent.kind  = (pos == '0) ? ENT_CMD : ENT_PARAM;
                ent.value = (pos == '0) ? {10'd0, gcmd} : {10'd0, pbyte};
                last      = (pos == glen);
            end
            ENT_DELAY: begin
                ent.kind  = ENT_DELAY;
                ent.value = 18'(SLEEP_US);
                last      = 1'b1;
            end
            default: begin
                ent.kind  = ENT_END;
                ent.value = '0;
                last      = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pinit_timer.sv
module pinit_timer #(
    parameter int CYC_PER_US = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [17:0] us_in,
    output logic        done
);

    typedef struct packed {
        logic [31:0] cnt;
        logic        run;
    } tmr_t;

    tmr_t        t_q, t_d;
    logic [31:0] total;

    always_comb begin
        t_d   = t_q;
        total = 32'(us_in) * 32'(CYC_PER_US);
        done  = t_q.run && (t_q.cnt == '0);
        if (load) begin
            t_d.cnt = (total == '0) ? '0 : total - 32'd1;
            t_d.run = 1'b1;
        end else if (done) begin
            t_d.run = 1'b0;
        end else if (t_q.run) begin
            t_d.cnt = t_q.cnt - 32'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R7
    tmr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.run && t_q.cnt != '0 && !load) |=> (t_q.cnt == $past(t_q.cnt) - 32'd1));

endmodule

// File: rtl/pinit_fill.sv
module pinit_fill #(
    parameter int PIXELS = 96000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);

    localparam int FW = $clog2(PIXELS + 1);

    logic [FW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        last  = (cnt_q == FW'(PIXELS - 1));
        if (clr)       cnt_d = '0;
        else if (step) cnt_d = last ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < FW'(PIXELS));

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
    import pinit_pkg::*;
#(
    parameter int COLS       = 240,
    parameter int ROWS       = 400,
    parameter int CYC_PER_US = 200,
    parameter int SLEEP_US   = 120000,
    parameter int DISP_US    = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        wr_stb,
    output logic        rs,
    output logic [17:0] wdata,
    output logic        busy,
    output logic        ready
);

    localparam int PIXELS = COLS * ROWS;

    typedef struct packed {
        seq_state_e       st;
        logic [GRP_W-1:0] grp;
        logic [POS_W-1:0] pos;
        logic             wr;
        logic             rs;
        logic [17:0]      data;
        logic             busy;
        logic             ready;
    } regs_t;

    regs_t       r_q, r_d;
    ent_t        ent;
    logic        grp_last;
    logic        tmr_load, tmr_done;
    logic [17:0] tmr_us;
    logic        fill_clr, fill_step, fill_last;

    pinit_rom #(.COLS(COLS), .ROWS(ROWS), .SLEEP_US(SLEEP_US)) u_rom (
        .grp (r_q.grp),
        .pos (r_q.pos),
        .ent (ent),
        .last(grp_last)
    );

    pinit_timer #(.CYC_PER_US(CYC_PER_US)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .us_in(tmr_us),
        .done (tmr_done)
    );

    pinit_fill #(.PIXELS(PIXELS)) u_fill (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (fill_clr),
        .step (fill_step),
        .last (fill_last)
    );

    always_comb begin
        r_d       = r_q;
        r_d.wr    = 1'b0;
        tmr_load  = 1'b0;
        tmr_us    = '0;
        fill_clr  = 1'b0;
        fill_step = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_WALK;
                    r_d.grp   = '0;
                    r_d.pos   = '0;
                    r_d.busy  = 1'b1;
                    r_d.ready = 1'b0;
                end
            end
            ST_WALK: begin
                case (ent.kind)
                    ENT_CMD, ENT_PARAM: begin
                        r_d.wr   = 1'b1;
                        r_d.rs   = (ent.kind == ENT_PARAM);
                        r_d.data = ent.value;
                        if (grp_last) begin
                            r_d.grp = r_q.grp + 1'b1;
                            r_d.pos = '0;
                        end else begin
                            r_d.pos = r_q.pos + 1'b1;
                        end
                    end
                    ENT_DELAY: begin
                        tmr_load = 1'b1;
                        tmr_us   = ent.value;
                        r_d.st   = ST_WAIT;
                        r_d.grp  = r_q.grp + 1'b1;
                        r_d.pos  = '0;
                    end
                    default: r_d.st = ST_FILL_CMD;
                endcase
            end
            ST_WAIT: begin
                if (tmr_done) r_d.st = ST_WALK;
            end
            ST_FILL_CMD: begin
                r_d.wr   = 1'b1;
                r_d.rs   = 1'b0;
                r_d.data = {10'd0, CMD_MEM_WR};
                fill_clr = 1'b1;
                r_d.st   = ST_FILL;
            end
            ST_FILL: begin
                r_d.wr    = 1'b1;
                r_d.rs    = 1'b1;
                r_d.data  = '0;
                fill_step = 1'b1;
                if (fill_last) r_d.st = ST_DISP;
            end
            ST_DISP: begin
                r_d.wr   = 1'b1;
                r_d.rs   = 1'b0;
                r_d.data = {10'd0, CMD_DISP_ON};
                tmr_load = 1'b1;
                tmr_us   = 18'(DISP_US);
                r_d.st   = ST_DISP_WAIT;
            end
            ST_DISP_WAIT: begin
                if (tmr_done) r_d.st = ST_REARM;
            end
            ST_REARM: begin
                r_d.wr   = 1'b1;
                r_d.rs   = 1'b0;
                r_d.data = {10'd0, CMD_MEM_WR};
                r_d.st   = ST_READY;
            end
            ST_READY: begin
                r_d.busy  = 1'b0;
                r_d.ready = 1'b1;
                if (start && r_q.ready) begin
                    r_d.st    = ST_WALK;
                    r_d.grp   = '0;
                    r_d.pos   = '0;
                    r_d.busy  = 1'b1;
                    r_d.ready = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_stb = r_q.wr;
    assign rs     = r_q.rs;
    assign wdata  = r_q.data;
    assign busy   = r_q.busy;
    assign ready  = r_q.ready;

    // R10
    busy_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && ready));

    // R10
    wr_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> busy);

    // R10
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> ready);

    // R13
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> (busy && !ready));

    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ready && start) |=> busy);

endmodule

// File: tb/panel_init_seq_test.sv
`timescale 1ns/1ps
module panel_init_seq_test;

    localparam int COLS = 24;
    localparam int ROWS = 20;
    localparam int CPU  = 3;
    localparam int SLP  = 50;
    localparam int DSP  = 10;
    localparam int SLP_CYC = SLP * CPU;
    localparam int DSP_CYC = DSP * CPU;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr_stb, rs, busy, ready;
    logic [17:0] wdata;

    panel_init_seq #(.COLS(COLS), .ROWS(ROWS), .CYC_PER_US(CPU),
                     .SLEEP_US(SLP), .DISP_US(DSP)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_stb(wr_stb),
        .rs(rs), .wdata(wdata), .busy(busy), .ready(ready)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        bit          rs;
        bit          known;
        logic [17:0] val;
        int          gmin;
        int          gmax;
        bit          fin;
        string       req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   last_cyc = 0;
    int   rdy_cyc = -1;
    bit   done_flag = 0;
    int   pend_gmin = 1;
    int   pend_gmax = 1;
    string pend_req = "R11";
    logic [7:0] cur_cmd = 8'h00;
    int   pidx = 0;
    logic [7:0] gam [3][20];
    logic [7:0] tim [3][5];

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(bit r, bit k, logic [17:0] v, string req, bit fin = 0);
        exp_t e;
        e.rs = r; e.known = k; e.val = v; e.gmin = pend_gmin; e.gmax = pend_gmax;
        e.fin = fin;
        e.req = (pend_gmax > 1) ? pend_req : req;
        q.push_back(e);
        pend_gmin = 1; pend_gmax = 1; pend_req = "R11";
    endtask

    task automatic push_cfg(logic [7:0] c, int n);
        push(0, 1, {10'd0, c}, "R3");
        for (int i = 0; i < n; i++) push(1, 0, '0, "R3");
    endtask

    task automatic build_expected();
        push_cfg(8'hB0, 1);  push_cfg(8'hB1, 1);  push_cfg(8'hB3, 5);
        push_cfg(8'hB4, 1);  push_cfg(8'hC0, 9);  push_cfg(8'hC1, 5);
        push_cfg(8'hC2, 5);  push_cfg(8'hC3, 5);  push_cfg(8'hC4, 4);
        push_cfg(8'hC8, 20); push_cfg(8'hC9, 20); push_cfg(8'hCA, 20);
        push_cfg(8'hD0, 6);  push_cfg(8'hD1, 3);  push_cfg(8'hD2, 2);
        push_cfg(8'hD3, 2);  push_cfg(8'hD4, 2);  push_cfg(8'hD8, 2);
        // R5 tearing-effect output and line
        push(0, 1, 18'h35, "R5"); push(1, 1, 18'h00, "R5");
        push(0, 1, 18'h44, "R5"); push(1, 1, 18'h00, "R5"); push(1, 1, 18'h00, "R5");
        // R6 windows
        push(0, 1, 18'h2A, "R6"); push(1, 1, 18'h00, "R6"); push(1, 1, 18'h00, "R6");
        push(1, 1, 18'((COLS - 1) >> 8), "R6"); push(1, 1, 18'((COLS - 1) & 255), "R6");
        push(0, 1, 18'h2B, "R6"); push(1, 1, 18'h00, "R6"); push(1, 1, 18'h00, "R6");
        push(1, 1, 18'((ROWS - 1) >> 8), "R6"); push(1, 1, 18'((ROWS - 1) & 255), "R6");
        // R7 sleep exit then wait
        push(0, 1, 18'h11, "R7");
        pend_gmin = SLP_CYC; pend_gmax = SLP_CYC + 4; pend_req = "R7";
        // R8 frame clear
        push(0, 1, 18'h2C, "R8");
        for (int i = 0; i < COLS * ROWS; i++) push(1, 1, 18'h0, "R8");
        // R9 display on, wait, re-arm memory write
        push(0, 1, 18'h29, "R9");
        pend_gmin = DSP_CYC; pend_gmax = DSP_CYC + 4; pend_req = "R9";
        push(0, 1, 18'h2C, "R9", 1);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // per-clock comparison against the reference stream
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && ready) chk(0, "R10", "busy and ready together", 1, 0);
            if (wr_stb) begin
                if (q.size() == 0) begin
                    chk(0, "R10", "write with nothing expected", wdata, 0);
                end else begin
                    exp_t e;
                    int gap;
                    e = q.pop_front();
                    gap = cyc - last_cyc;
                    chk(rs == e.rs, e.req, "rs", rs, e.rs);
                    if (e.known) chk(wdata == e.val, e.req, "wdata", wdata, e.val);
                    else chk(wdata[17:8] == 10'd0, "R3", "upper data bits", wdata, wdata[7:0]);
                    chk(gap >= e.gmin && gap <= e.gmax, e.req, "gap", gap, e.gmin);
                    chk(busy == 1'b1, "R10", "busy during write", busy, 1);
                    if (!rs) begin
                        cur_cmd = wdata[7:0];
                        pidx = 0;
                    end else begin
                        if (cur_cmd >= 8'hC8 && cur_cmd <= 8'hCA && pidx < 20)
                            gam[cur_cmd - 8'hC8][pidx] = wdata[7:0];
                        if (cur_cmd >= 8'hC1 && cur_cmd <= 8'hC3 && pidx < 5)
                            tim[cur_cmd - 8'hC1][pidx] = wdata[7:0];
                        pidx++;
                    end
                    last_cyc = cyc;
                    if (e.fin) rdy_cyc = cyc + 1;
                end
            end
            if (cyc == rdy_cyc) begin
                chk(ready == 1'b1 && busy == 1'b0, "R10", "ready after final write",
                    {ready, busy}, 2'b10);
                done_flag = 1;
            end
            if (cyc > 20000) begin
                chk(0, "R10", "watchdog expired", cyc, 20000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    task automatic pulse_start(string req);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        last_cyc = cyc;
        chk(busy == 1'b1 && ready == 1'b0, req, "busy after start", {busy, ready}, 2'b10);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(wr_stb == 0 && busy == 0 && ready == 0, "R1", "outputs in reset",
            {wr_stb, busy, ready}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(wr_stb == 0 && busy == 0 && ready == 0, "R1", "idle before start",
            {wr_stb, busy, ready}, 0);

        // R2 first run
        build_expected();
        pulse_start("R2");
        // R12 start during the table walk and during the sleep wait
        repeat (40) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (160) @(negedge clk);
        chk(wr_stb == 0 && busy == 1, "R12", "inside sleep wait", {wr_stb, busy}, 1);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait (done_flag);
        done_flag = 0;

        // R10 ready holds and no writes
        repeat (20) @(negedge clk);
        chk(ready == 1 && busy == 0 && wr_stb == 0, "R10", "idle in ready",
            {ready, busy, wr_stb}, 3'b100);
        chk(q.size() == 0, "R8", "stream fully consumed", q.size(), 0);

        // R4 repeated lists
        for (int i = 0; i < 20; i++) begin
            chk(gam[1][i] == gam[0][i] && gam[2][i] == gam[0][i], "R4",
                "gamma list byte", gam[1][i], gam[0][i]);
        end
        for (int i = 0; i < 5; i++) begin
            chk(tim[1][i] == tim[0][i] && tim[2][i] == tim[0][i], "R4",
                "timing list byte", tim[1][i], tim[0][i]);
        end

        // R13 restart from ready
        build_expected();
        pulse_start("R13");
        wait (done_flag);
        repeat (5) @(negedge clk);
        chk(ready == 1 && q.size() == 0, "R13", "second run complete", ready, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule